// File: doc/BRIEF.md
# Serial EEPROM Read Master

This block reads one 16-bit word at a time from a three-wire serial EEPROM. It drives the part's chip select, serial clock and command data line, and samples the part's data output. A single-cycle start request with a word address makes the block assert chip select, send a read command made of a start bit, a two-bit read opcode and the address, and then clock in sixteen data bits, most significant bit first. Chip select is then released and a one-cycle done pulse presents the word.

Every serial bit takes two phases of equal length, clock low then clock high, each `HALF_CLKS` system clocks long. The address field is 6 or 8 bits wide, chosen per request. A probe request reads the top address with 8-bit framing and reports which width the attached part uses: a part with a 6-bit address finishes its command early and drives a dummy zero on its output while an 8-bit part is still taking address bits with its output released high.

Top module: `uwire_rd_master`

## Requirements
- R1: While reset is asserted, and from the first cycle after it, eep_cs_o, eep_sk_o, eep_di_o, busy_o and done_o are 0; an asserted reset ends a transaction in progress at once.
- R2: A start_i seen while the block is idle is accepted: in the next cycle busy_o and eep_cs_o are 1. A start_i seen while busy_o is 1 is ignored and does not change the running transaction's length or result.
- R3: The command line carries 1, 1, 0 and then the address, MSB first: addr_i[7:0] when wide_addr_i is 1 (11 command bits), addr_i[5:0] when wide_addr_i is 0 (9 command bits).
- R4: Each serial bit holds eep_sk_o low for HALF_CLKS cycles and then high for HALF_CLKS cycles; eep_di_o changes only while the clock is low.
- R5: After the command, 16 data bits are taken from eep_do_i MSB first, each sampled at the end of its clock-high phase; data_o holds the word when done_o is 1.
- R6: Chip select rises with acceptance, before the first clock rise, and falls in the cycle done_o rises; the transaction lasts 2*HALF_CLKS*(command bits + 16) cycles from acceptance to done.
- R7: done_o is a one-cycle pulse during which busy_o is already 0; a start_i in that cycle is accepted.
- R8: A start_i with probe_i at 1 reads address 255 with 8-bit framing (27 serial bits); probe_wide_o then takes the eep_do_i sample of the 9th clock rise, which is bit 18 of the whole 27-bit sampled stream counted from the last sample as bit 0 (1 means 8-bit addressing, 0 means 6-bit). probe_wide_o changes only when a probe completes.
- R9: During the data phase eep_di_o is 0, and eep_sk_o is never 1 while eep_cs_o is 0.
- R10: addr_i, wide_addr_i and probe_i are taken only in the accepting cycle; changes during a transaction have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a read (taken only when idle) |
| addr_i | input | 8 | Word address; low 6 bits used in narrow mode |
| wide_addr_i | input | 1 | 1 selects 8-bit address framing, 0 selects 6-bit |
| probe_i | input | 1 | With start_i, run an address-width probe |
| busy_o | output | 1 | A transaction is running |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 16 | Word read by the last transaction |
| probe_wide_o | output | 1 | Result of the last probe: 1 for 8-bit addressing |
| eep_cs_o | output | 1 | EEPROM chip select, active high |
| eep_sk_o | output | 1 | EEPROM serial clock |
| eep_di_o | output | 1 | Command bits to the EEPROM |
| eep_do_i | input | 1 | Data bits from the EEPROM |

## Verification
The completion of one read and the acceptance of the next can fall in the same cycle, since busy_o is already low while done_o is high. The bench raises start_i in exactly the cycle where done_o is seen, then judges that busy_o is high one cycle later and that the chained read has full length and the word of its own address. A start pulse placed in the middle of a running read checks the opposite case, where the request must leave length and result untouched.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  localparam int unsigned UW_DATA_W     = 16;
  localparam int unsigned UW_PRE_W      = 3;
  localparam int unsigned UW_AW_WIDE    = 8;
  localparam int unsigned UW_AW_NARROW  = 6;
  localparam int unsigned UW_CMD_MAX    = UW_PRE_W + UW_AW_WIDE;
  localparam int unsigned UW_LEN_WIDE   = UW_CMD_MAX + UW_DATA_W;
  localparam int unsigned UW_LEN_NARROW = UW_PRE_W + UW_AW_NARROW + UW_DATA_W;
  localparam int unsigned UW_IDX_W      = $clog2(UW_LEN_WIDE);
  // Bit of the full sampled stream (last sample = bit 0) that reflects the
  // sample taken right after a narrow part has seen its whole command.
  localparam int unsigned UW_PROBE_BIT  = UW_LEN_WIDE - UW_PRE_W - UW_AW_NARROW;
  localparam logic [UW_PRE_W-1:0]   UW_RD_PRE     = 3'b110;
  localparam logic [UW_AW_WIDE-1:0] UW_PROBE_ADDR = '1;

  typedef enum logic [1:0] {
    UW_IDLE = 2'd0,
    UW_LOW  = 2'd1,
    UW_HIGH = 2'd2
  } uw_state_e;
endpackage

// File: rtl/uwire_phase_timer.sv
module uwire_phase_timer #(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || expire_o) cnt_d = '0;
    else                    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: a phase always starts counting from zero when the sequencer starts
  a_r4_fresh_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !$past(run_i)) |-> (cnt_q == '0));
endmodule

// File: rtl/uwire_seq_ctrl.sv
module uwire_seq_ctrl
  import uwire_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wide_i,
  input  logic probe_i,
  input  logic expire_i,
  output logic load_o,
  output logic shift_o,
  output logic finish_o,
  output logic probe_act_o,
  output logic sk_o,
  output logic busy_o,
  output logic done_o
);
  localparam logic [UW_IDX_W-1:0] LAST_WIDE   = UW_IDX_W'(UW_LEN_WIDE - 1);
  localparam logic [UW_IDX_W-1:0] LAST_NARROW = UW_IDX_W'(UW_LEN_NARROW - 1);

  uw_state_e           st_q, st_d;
  logic [UW_IDX_W-1:0] idx_q, idx_d;
  logic [UW_IDX_W-1:0] last_q, last_d;
  logic                probe_q, probe_d;
  logic                done_q, done_d;

  assign load_o   = (st_q == UW_IDLE) && start_i;
  assign shift_o  = (st_q == UW_HIGH) && expire_i;
  assign finish_o = shift_o && (idx_q == last_q);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    last_d  = last_q;
    probe_d = probe_q;
    done_d  = finish_o;
    case (st_q)
      UW_IDLE: begin
        if (load_o) begin
          st_d    = UW_LOW;
          idx_d   = '0;
          last_d  = (wide_i || probe_i) ? LAST_WIDE : LAST_NARROW;
          probe_d = probe_i;
        end
      end
      UW_LOW: begin
        if (expire_i) st_d = UW_HIGH;
      end
      UW_HIGH: begin
        if (expire_i) begin
          if (finish_o) begin
            st_d = UW_IDLE;
          end else begin
            st_d  = UW_LOW;
            idx_d = idx_q + UW_IDX_W'(1);
          end
        end
      end
      default: st_d = UW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= UW_IDLE;
      idx_q   <= '0;
      last_q  <= LAST_NARROW;
      probe_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      last_q  <= last_d;
      probe_q <= probe_d;
      done_q  <= done_d;
    end
  end

  assign busy_o      = (st_q != UW_IDLE);
  assign sk_o        = (st_q == UW_HIGH);
  assign done_o      = done_q;
  assign probe_act_o = probe_q;

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: busy is already released while done is shown
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R2: a transaction only begins on a request
  a_r2_begin_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
  // R6: the bit index never passes the frame end
  a_r6_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q <= last_q));
endmodule

// File: rtl/uwire_frame_shift.sv
module uwire_frame_shift
  import uwire_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic                  wide_i,
  input  logic                  probe_i,
  input  logic [UW_AW_WIDE-1:0] addr_i,
  input  logic                  sdi_i,
  output logic                  cmd_bit_o,
  output logic [UW_DATA_W-1:0]  word_o,
  output logic                  probe_bit_o
);
  // The capture keeps only the bits that are ever looked at: the data word
  // and, for a probe, the stream bit at UW_PROBE_BIT (read one shift early).
  localparam int unsigned CAP_W = UW_PROBE_BIT;
  localparam int unsigned PAD_W = UW_AW_WIDE - UW_AW_NARROW;

  logic [UW_CMD_MAX-1:0] out_q, out_d;
  logic [CAP_W-1:0]      cap_q, cap_d;
  logic [UW_CMD_MAX-1:0] frame_sel;

  always_comb begin
    if (probe_i)     frame_sel = {UW_RD_PRE, UW_PROBE_ADDR};
    else if (wide_i) frame_sel = {UW_RD_PRE, addr_i};
    else             frame_sel = {UW_RD_PRE, addr_i[UW_AW_NARROW-1:0], {PAD_W{1'b0}}};
  end

  always_comb begin
    out_d = out_q;
    cap_d = cap_q;
    if (load_i) begin
      out_d = frame_sel;
      cap_d = '0;
    end else if (shift_i) begin
      out_d = {out_q[UW_CMD_MAX-2:0], 1'b0};
      cap_d = {cap_q[CAP_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      cap_q <= '0;
    end else begin
      out_q <= out_d;
      cap_q <= cap_d;
    end
  end

  assign cmd_bit_o   = out_q[UW_CMD_MAX-1];
  assign word_o      = cap_q[UW_DATA_W-1:0];
  assign probe_bit_o = cap_q[CAP_W-1];

  // R3: a freshly loaded frame always leads with the start bit
  a_r3_start_bit_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cmd_bit_o);
endmodule

// File: rtl/uwire_rd_master.sv
module uwire_rd_master
  import uwire_pkg::*;
#(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [UW_AW_WIDE-1:0] addr_i,
  input  logic                  wide_addr_i,
  input  logic                  probe_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [UW_DATA_W-1:0]  data_o,
  output logic                  probe_wide_o,
  output logic                  eep_cs_o,
  output logic                  eep_sk_o,
  output logic                  eep_di_o,
  input  logic                  eep_do_i
);
  logic expire, load, shift, finish, probe_act, busy, sk, cmd_bit, probe_bit;
  logic probe_q, probe_d;

  uwire_phase_timer #(.HALF_CLKS(HALF_CLKS)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (busy),
    .expire_o (expire)
  );

  uwire_seq_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .wide_i      (wide_addr_i),
    .probe_i     (probe_i),
    .expire_i    (expire),
    .load_o      (load),
    .shift_o     (shift),
    .finish_o    (finish),
    .probe_act_o (probe_act),
    .sk_o        (sk),
    .busy_o      (busy),
    .done_o      (done_o)
  );

  uwire_frame_shift shift_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .shift_i     (shift),
    .wide_i      (wide_addr_i),
    .probe_i     (probe_i),
    .addr_i      (addr_i),
    .sdi_i       (eep_do_i),
    .cmd_bit_o   (cmd_bit),
    .word_o      (data_o),
    .probe_bit_o (probe_bit)
  );

  always_comb begin
    probe_d = probe_q;
    if (finish && probe_act) probe_d = probe_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) probe_q <= 1'b0;
    else        probe_q <= probe_d;
  end

  assign probe_wide_o = probe_q;
  assign busy_o       = busy;
  assign eep_cs_o     = busy;
  assign eep_sk_o     = sk;
  assign eep_di_o     = cmd_bit;

  // R4: command line is steady across a clock-high phase
  a_r4_di_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (eep_sk_o && $past(eep_sk_o)) |-> $stable(eep_di_o));
  // R9: no serial clock without chip select
  a_r9_sk_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
    eep_sk_o |-> eep_cs_o);
  // R6: chip select is released exactly as the completion pulse appears
  a_r6_cs_drop_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eep_cs_o) |-> done_o);
  // R8: the width result moves only on a completion
  a_r8_probe_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(probe_wide_o) |-> done_o);
endmodule

// File: tb/uwire_rd_master_tb_top.sv
module uwire_eep_model (
  input  logic        cs,
  input  logic        sk,
  input  logic        di,
  input  logic        wide,
  output logic        dout,
  output int          rises,
  output logic [10:0] cmd_seen,
  output logic        data_di_hi
);
  logic [10:0] cmdsh;
  logic [15:0] word;
  logic        valid;
  int          r, aw, j;

  function automatic logic [15:0] word_at(input logic [7:0] x);
    return {x, ~x} ^ 16'h3C5A;
  endfunction

  initial begin
    dout = 1'b1; rises = 0; cmd_seen = '0; data_di_hi = 1'b0;
    cmdsh = '0; word = '0; valid = 1'b0;
  end

  always @(posedge cs or posedge sk) begin
    if (!sk) begin
      dout = 1'b1; rises = 0; cmd_seen = '0; data_di_hi = 1'b0;
      cmdsh = '0; valid = 1'b0;
    end else begin
      r  = rises;
      aw = wide ? 8 : 6;
      if (r < 11) cmd_seen[10-r] = di;
      if (r < 3 + aw) cmdsh = {cmdsh[9:0], di};
      if (r == 2 + aw) begin
        valid = (cmdsh[aw+2 -: 3] == 3'b110);
        word  = word_at(wide ? cmdsh[7:0] : {2'b00, cmdsh[5:0]});
        dout  = valid ? 1'b0 : 1'b1;
      end else if (r > 2 + aw) begin
        j = r - 3 - aw;
        dout = (valid && j < 16) ? word[15-j] : 1'b1;
        if (di) data_di_hi = 1'b1;
      end
      rises = r + 1;
    end
  end
endmodule

module uwire_rd_master_tb_top;
  localparam int HALF = 3;
  localparam int LEN_W = 27;
  localparam int LEN_N = 25;
  // entry: {device is 8-bit, request 8-bit framing, address}
  localparam logic [9:0] VEC [0:5] = '{10'h300, 10'h3A7, 10'h3FF,
                                       10'h015, 10'h0FF, 10'h02A};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, wide_addr_i, probe_i;
  logic [7:0]  addr_i;
  logic        busy_o, done_o, probe_wide_o;
  logic [15:0] data_o;
  logic        eep_cs_o, eep_sk_o, eep_di_o, eep_do_i;
  logic        dev_wide;
  int          rises;
  logic [10:0] cmd_seen;
  logic        data_di_hi;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  uwire_rd_master #(.HALF_CLKS(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .wide_addr_i(wide_addr_i), .probe_i(probe_i), .busy_o(busy_o),
    .done_o(done_o), .data_o(data_o), .probe_wide_o(probe_wide_o),
    .eep_cs_o(eep_cs_o), .eep_sk_o(eep_sk_o), .eep_di_o(eep_di_o),
    .eep_do_i(eep_do_i)
  );

  uwire_eep_model mdl_i (
    .cs(eep_cs_o), .sk(eep_sk_o), .di(eep_di_o), .wide(dev_wide),
    .dout(eep_do_i), .rises(rises), .cmd_seen(cmd_seen), .data_di_hi(data_di_hi)
  );

  function automatic logic [15:0] word_at(input logic [7:0] x);
    return {x, ~x} ^ 16'h3C5A;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // phase-length monitor (R4)
  int hi_run, lo_run;
  logic prev_sk, prev_cs, phase_bad;
  initial begin hi_run = 0; lo_run = 0; prev_sk = 0; prev_cs = 0; phase_bad = 0; end
  always @(negedge clk) begin
    if (!rst_n) begin
      hi_run = 0; lo_run = 0; prev_sk = 0; prev_cs = 0;
    end else begin
      if (eep_cs_o) begin
        if (eep_sk_o) begin
          if (!prev_sk && lo_run != HALF) phase_bad = 1;
          lo_run = 0; hi_run++;
        end else begin
          if (prev_sk && hi_run != HALF) phase_bad = 1;
          hi_run = 0; lo_run++;
        end
      end else begin
        if (prev_cs && hi_run != HALF) phase_bad = 1;
        hi_run = 0; lo_run = 0;
      end
      prev_sk = eep_sk_o; prev_cs = eep_cs_o;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  // Start a read; returns at the negedge where done_o is seen.
  task automatic do_read(input bit wide, input logic [7:0] addr, input bit probe,
                         input bit immediate, input int poke,
                         output int cycles, output bit busy_seen, output bit cs_seen);
    if (!immediate) @(negedge clk);
    addr_i = addr; wide_addr_i = wide; probe_i = probe; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; probe_i = 1'b0;
    busy_seen = busy_o; cs_seen = eep_cs_o;
    addr_i = ~addr; wide_addr_i = ~wide;          // R10: late changes
    cycles = 0;
    while (!done_o && cycles < 2000) begin
      @(negedge clk);
      cycles++;
      if (poke > 0 && cycles == poke) begin
        start_i = 1'b1; addr_i = 8'h11; probe_i = 1'b1;
      end else begin
        start_i = 1'b0; probe_i = 1'b0;
      end
    end
    start_i = 1'b0;
  endtask

  initial begin
    int  cyc;
    bit  bs, cs;
    logic [7:0]  a;
    logic [10:0] exp_cmd;
    int  len;
    rst_n = 1'b0; start_i = 0; addr_i = 0; wide_addr_i = 0; probe_i = 0; dev_wide = 1;
    repeat (3) @(negedge clk);
    chk("R1", "cs in reset", eep_cs_o, 0);
    chk("R1", "sk in reset", eep_sk_o, 0);
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "done in reset", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "di after reset", eep_di_o, 0);
    chk("R9", "sk idle", eep_sk_o, 0);

    // table of reads
    for (int i = 0; i < 6; i++) begin
      dev_wide = VEC[i][9];
      a = VEC[i][7:0];
      len = VEC[i][8] ? LEN_W : LEN_N;
      exp_cmd = VEC[i][8] ? {3'b110, a} : {3'b110, a[5:0], 2'b00};
      do_read(VEC[i][8], a, 1'b0, 1'b0, 0, cyc, bs, cs);
      chk("R2", "busy after accept", bs, 1);
      chk("R6", "cs after accept", cs, 1);
      chk("R6", "transaction length", cyc, 2 * HALF * len);
      chk("R3", "command bits", cmd_seen, exp_cmd);
      chk("R3", "clock rises", rises, len);
      chk("R5", "data word", data_o, word_at(VEC[i][8] ? a : {2'b00, a[5:0]}));
      chk("R10", "late input change ignored", data_o, word_at(VEC[i][8] ? a : {2'b00, a[5:0]}));
      chk("R9", "di low in data phase", data_di_hi, 0);
      chk("R7", "busy low with done", busy_o, 0);
      chk("R4", "phase lengths", phase_bad, 0);
      @(negedge clk);
      chk("R7", "done one cycle", done_o, 0);
    end

    // R2: start while busy is ignored
    dev_wide = 1;
    do_read(1'b1, 8'h6B, 1'b0, 1'b0, 40, cyc, bs, cs);
    chk("R2", "length with stray start", cyc, 2 * HALF * LEN_W);
    chk("R2", "data with stray start", data_o, word_at(8'h6B));
    @(negedge clk);
    chk("R2", "stray start not queued", busy_o, 0);

    // R8: probe on an 8-bit part
    dev_wide = 1;
    do_read(1'b0, 8'h12, 1'b1, 1'b0, 0, cyc, bs, cs);
    chk("R8", "probe length", cyc, 2 * HALF * LEN_W);
    chk("R8", "probe address 255 word", data_o, word_at(8'hFF));
    chk("R8", "probe result 8-bit", probe_wide_o, 1);

    // R8: probe on a 6-bit part
    dev_wide = 0;
    do_read(1'b1, 8'h12, 1'b1, 1'b0, 0, cyc, bs, cs);
    chk("R8", "probe rises", rises, LEN_W);
    chk("R8", "probe result 6-bit", probe_wide_o, 0);

    // R8: normal read leaves the probe result alone
    dev_wide = 1;
    do_read(1'b1, 8'hC3, 1'b0, 1'b0, 0, cyc, bs, cs);
    chk("R8", "probe result kept", probe_wide_o, 0);
    chk("R5", "data after probe", data_o, word_at(8'hC3));

    // R7: chained start in the done cycle
    do_read(1'b1, 8'h5C, 1'b0, 1'b1, 0, cyc, bs, cs);
    chk("R7", "chained start accepted", bs, 1);
    chk("R7", "chained length", cyc, 2 * HALF * LEN_W);
    chk("R7", "chained data", data_o, word_at(8'h5C));
    chk("R4", "phase lengths chained", phase_bad, 0);

    // R1: reset in the middle of a transaction
    @(negedge clk);
    addr_i = 8'h01; wide_addr_i = 1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "cs dropped by reset", eep_cs_o, 0);
    chk("R1", "busy dropped by reset", busy_o, 0);
    chk("R1", "sk dropped by reset", eep_sk_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    dev_wide = 0;
    do_read(1'b0, 8'h33, 1'b0, 1'b0, 0, cyc, bs, cs);
    chk("R1", "read after reset", data_o, word_at(8'h33));

    summary();
    $finish;
  end
endmodule